// File: doc/BRIEF.md
# Handshaked FIFO with status flags

This block is a 64-word first-in first-out buffer whose word width is set by a parameter (8 or 9 bits). A producer offers a word by raising `shift_in` for one clock while `in_ready` is high. A consumer takes the oldest word by raising `shift_out` while `out_ready` is high. A strobe that arrives while its ready signal is low is dropped and has no effect.

The head word appears on `data_out` as soon as it is stored, so the consumer sees a word before it takes it. An output-enable input forces the bus to zero when low, which stands in for a released bus. Two status outputs give coarse fill information. `near_edge` warns that the buffer is close to either end. `half_up` shows that at least half the storage is in use.

The ready outputs are plain functions of the stored occupancy, with no pipeline stage. Instances can therefore be chained for depth by feeding one instance's `out_ready` into the next instance's `shift_in`, and moving a word only when the downstream `in_ready` is high. Instances can also sit side by side for width, with their ready outputs combined by AND. Everything runs on one clock, and reset is synchronous and active-low.

Top module: `handshake_fifo`

## Requirements
- R1: While `rst_n` is low at a rising clock edge the buffer is emptied. After that edge `in_ready` is 1, `out_ready` is 0, `near_edge` is 1 and `half_up` is 0.
- R2: `in_ready` is 1 exactly when fewer than 64 words are held. A `shift_in` while `in_ready` is 0 stores nothing and leaves the contents unchanged.
- R3: `out_ready` is 1 exactly when at least one word is held. A `shift_out` while `out_ready` is 0 removes nothing.
- R4: Words are delivered in the order they were accepted. While `out_ready` and `out_en` are both 1, `data_out` shows the oldest held word in the same cycle.
- R5: `near_edge` is 1 exactly when the occupancy is 8 or fewer (including 0) or 56 or more.
- R6: `half_up` is 1 exactly when the occupancy is 32 or more.
- R7: While `out_en` is 0, `data_out` is all zeros. `out_en` has no effect on the stored words or on their order.
- R8: `shift_in` and `shift_out` together, with 1 to 63 words held, store one word and remove one word in the same cycle, so the occupancy stays the same. When the buffer is full only the removal happens. When it is empty only the store happens.
- R9: Two instances chained for depth, with the downstream `shift_in` driven by the upstream `out_ready` and the upstream `shift_out` driven by `out_ready` AND the downstream `in_ready`, act as one ordered buffer that holds 128 words and loses no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; empties the buffer |
| shift_in | input | 1 | Store strobe; acts only while `in_ready` is 1 |
| data_in | input | WIDTH | Word to store |
| in_ready | output | 1 | Room for at least one more word |
| shift_out | input | 1 | Remove strobe; acts only while `out_ready` is 1 |
| out_ready | output | 1 | At least one word is held |
| out_en | input | 1 | Enables `data_out`; zero when low |
| data_out | output | WIDTH | Oldest held word, gated by `out_en` |
| near_edge | output | 1 | Occupancy at most 8 or at least 56 |
| half_up | output | 1 | Occupancy at least 32 |

## Verification
The main instance is built with the defaults: a width of 9 and a depth of 64. With these values, 9-bit patterns whose top bit changes can be checked. The buffer can also be filled to its limit, which tests every flag threshold on both sides (8/9, 31/32, 55/56, 63/64).

A separate pair of 8-bit instances is chained for depth. That pair shows the narrow width, and it shows that 70 words sent through a chain whose downstream half has filled arrive complete and in order.

// File: rtl/hsf_pkg.sv
// Package hsf_pkg
// Shared types for the handshaked FIFO. Assumes one clock domain.
package hsf_pkg;

    // Status bundle derived from the occupancy count.
    typedef struct packed {
        logic can_take;   // room for another word
        logic has_word;   // at least one word held
        logic edge_zone;  // close to empty or close to full
        logic half_up;    // half or more in use
    } hsf_status_t;

endpackage

// File: rtl/hsf_ctrl.sv
// Module hsf_ctrl
// Owns the read and write pointers and the occupancy count. It turns the
// strobes into write and read enables, using the ready flags supplied by
// hsf_status. Assumes the strobes are synchronous to clk. Reset is
// synchronous and active-low.
module hsf_ctrl #(
    parameter int DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_req,
    input  logic                           pop_req,
    input  logic                           can_take,
    input  logic                           has_word,
    output logic                           wr_en,
    output logic [$clog2(DEPTH)-1:0]       wr_addr,
    output logic [$clog2(DEPTH)-1:0]       rd_addr,
    output logic [$clog2(DEPTH+1)-1:0]     level
);
    localparam int AW   = $clog2(DEPTH);
    localparam int LW   = $clog2(DEPTH + 1);
    localparam bit POW2 = ((1 << AW) == DEPTH);

    logic          rd_en;
    logic [AW-1:0] wr_next;
    logic [AW-1:0] rd_next;

    // Qualify each strobe with its ready flag; strobes without a ready flag are dropped.
    always_comb begin
        wr_en = push_req && can_take;
        rd_en = pop_req && has_word;
    end

    // Pointer increment; a power-of-two depth wraps on its own, any other depth needs a compare.
    generate
        if (POW2) begin : g_wrap_free
            always_comb begin
                wr_next = wr_addr + 1'b1;
                rd_next = rd_addr + 1'b1;
            end
        end else begin : g_wrap_cmp
            always_comb begin
                wr_next = (wr_addr == AW'(DEPTH - 1)) ? '0 : wr_addr + 1'b1;
                rd_next = (rd_addr == AW'(DEPTH - 1)) ? '0 : rd_addr + 1'b1;
            end
        end
    endgenerate

    // Advance the pointers on accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            rd_addr <= '0;
        end else begin
            if (wr_en) wr_addr <= wr_next;
            if (rd_en) rd_addr <= rd_next;
        end
    end

    // Track the occupancy; a store and a removal together leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (wr_en && !rd_en) begin
            level <= level + LW'(1);
        end else if (rd_en && !wr_en) begin
            level <= level - LW'(1);
        end
    end

    // R1: a reset edge leaves the buffer empty.
    a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> (level == '0));

    // R2: a store strobe while full (and no removal) changes nothing.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !can_take && !pop_req) |=> $stable(level));

    // R3: a removal strobe while empty (and no store) changes nothing.
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !has_word && !push_req) |=> $stable(level));

    // R8: a store and a removal accepted together keep the occupancy.
    a_r8_both_keep_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && can_take && has_word) |=> $stable(level));

endmodule

// File: rtl/hsf_store.sv
// Module hsf_store
// Two-port word storage with one synchronous write port and one
// combinational read port, so the head word is visible without a clock.
// Assumes the write address is never the address of an unread word.
module hsf_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Write the accepted word into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    // Present the word at the read pointer.
    always_comb rd_data = cells[rd_addr];

endmodule

// File: rtl/hsf_status.sv
// Module hsf_status
// Decodes the occupancy into the ready flags and the two fill flags.
// Assumes 0 <= level <= DEPTH and NEAR_LOW < HALF_AT <= NEAR_HIGH.
module hsf_status #(
    parameter int DEPTH     = 64,
    parameter int NEAR_LOW  = 8,
    parameter int NEAR_HIGH = 56,
    parameter int HALF_AT   = 32
) (
    input  logic [$clog2(DEPTH+1)-1:0] level,
    output hsf_pkg::hsf_status_t       stat
);
    localparam int LW = $clog2(DEPTH + 1);

    // Threshold compares on the stored count.
    always_comb begin
        stat.can_take  = (level != LW'(DEPTH));
        stat.has_word  = (level != '0);
        stat.edge_zone = (level <= LW'(NEAR_LOW)) || (level >= LW'(NEAR_HIGH));
        stat.half_up   = (level >= LW'(HALF_AT));
    end

endmodule

// File: rtl/handshake_fifo.sv
// Module handshake_fifo
// Top of the handshaked FIFO: strobe-and-ready ports, an output-enabled data
// bus and fill flags. Assumes a single clock; reset is synchronous and
// active-low. The ready outputs are combinational from state, so instances
// may be chained for depth or width.
module handshake_fifo #(
    parameter int WIDTH      = 9,
    parameter int DEPTH      = 64,
    parameter int LOW_MARGIN = 8,
    parameter int TOP_MARGIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             in_ready,
    input  logic             shift_out,
    output logic             out_ready,
    input  logic             out_en,
    output logic [WIDTH-1:0] data_out,
    output logic             near_edge,
    output logic             half_up
);
    localparam int AW        = $clog2(DEPTH);
    localparam int LW        = $clog2(DEPTH + 1);
    localparam int NEAR_HIGH = DEPTH - TOP_MARGIN;
    localparam int HALF_AT   = DEPTH / 2;

    hsf_pkg::hsf_status_t stat;
    logic                 wr_en;
    logic [AW-1:0]        wr_addr;
    logic [AW-1:0]        rd_addr;
    logic [LW-1:0]        level;
    logic [WIDTH-1:0]     head;

    hsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (shift_in),
        .pop_req  (shift_out),
        .can_take (stat.can_take),
        .has_word (stat.has_word),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .level    (level)
    );

    hsf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (data_in),
        .rd_addr (rd_addr),
        .rd_data (head)
    );

    hsf_status #(
        .DEPTH     (DEPTH),
        .NEAR_LOW  (LOW_MARGIN),
        .NEAR_HIGH (NEAR_HIGH),
        .HALF_AT   (HALF_AT)
    ) u_status (
        .level (level),
        .stat  (stat)
    );

    // Drive the handshake and flag outputs from the status bundle.
    always_comb begin
        in_ready  = stat.can_take;
        out_ready = stat.has_word;
        near_edge = stat.edge_zone;
        half_up   = stat.half_up;
    end

    // Gate the head word with the output enable; zero stands for a released bus.
    always_comb data_out = out_en ? head : '0;

    // R3: out_ready only drops on a cycle that removed a word.
    a_r3_drop_needs_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_ready) |-> $past(shift_out));

    // R2: in_ready only drops on a cycle that stored a word.
    a_r2_drop_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(shift_in));

    // R5: an empty buffer always reports the near-edge flag.
    a_r5_empty_is_near: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> near_edge);

    // R6: a buffer with no room is always at least half full.
    a_r6_full_is_half: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> half_up);

endmodule

// File: tb/handshake_fifo_tb.sv
`timescale 1ns/100ps
module handshake_fifo_tb;
    localparam int W  = 9;
    localparam int CW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_in = 1'b0, shift_out = 1'b0, out_en = 1'b1;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] data_out;
    logic         in_ready, out_ready, near_edge, half_up;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] q[$];

    always #2 clk = ~clk;

    handshake_fifo #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .data_in(data_in),
        .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
        .out_en(out_en), .data_out(data_out), .near_edge(near_edge), .half_up(half_up)
    );

    // Depth chain of two 8-bit instances (R9).
    logic          c_si = 1'b0, c_so = 1'b0;
    logic [CW-1:0] c_din = '0;
    logic [CW-1:0] up_dout, dn_dout;
    logic          up_ir, up_or, dn_ir, dn_or, up_ne, up_hf, dn_ne, dn_hf;
    logic          link_move;
    assign link_move = up_or && dn_ir;

    handshake_fifo #(.WIDTH(CW)) u_up (
        .clk(clk), .rst_n(rst_n), .shift_in(c_si), .data_in(c_din),
        .in_ready(up_ir), .shift_out(link_move), .out_ready(up_or),
        .out_en(1'b1), .data_out(up_dout), .near_edge(up_ne), .half_up(up_hf)
    );
    handshake_fifo #(.WIDTH(CW)) u_dn (
        .clk(clk), .rst_n(rst_n), .shift_in(up_or), .data_in(up_dout),
        .in_ready(dn_ir), .shift_out(c_so), .out_ready(dn_or),
        .out_en(1'b1), .data_out(dn_dout), .near_edge(dn_ne), .half_up(dn_hf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare flags against the model occupancy.
    task automatic check_state();
        int n = q.size();
        chk("R2 in_ready", 32'(in_ready), 32'(n < 64));
        chk("R3 out_ready", 32'(out_ready), 32'(n > 0));
        chk("R5 near_edge", 32'(near_edge), 32'(n <= 8 || n >= 56));
        chk("R6 half_up", 32'(half_up), 32'(n >= 32));
    endtask

    // Driver: one cycle of strobes, starting at posedge+1.
    task automatic cyc(input logic si, input logic so, input logic [W-1:0] d);
        shift_in = si; shift_out = so; data_in = d;
        @(negedge clk);
        if (si && in_ready) q.push_back(d);
        @(posedge clk); #1;
        shift_in = 1'b0; shift_out = 1'b0;
        check_state();
    endtask

    // Monitor: pops the scoreboard on every accepted removal.
    always @(negedge clk) begin
        if (rst_n && shift_out && out_ready && out_en) begin
            if (q.size() == 0) chk("R4 unexpected word", 32'(data_out), 32'h0);
            else begin
                chk("R4 order", 32'(data_out), 32'(q[0]));
                void'(q.pop_front());
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; shift_in = 1'b0; shift_out = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        q.delete();
        chk("R1 in_ready", 32'(in_ready), 32'h1);
        chk("R1 out_ready", 32'(out_ready), 32'h0);
        chk("R1 near_edge", 32'(near_edge), 32'h1);
        chk("R1 half_up", 32'(half_up), 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        do_reset();
        // R3: removal while empty is ignored.
        cyc(1'b0, 1'b1, '0);
        // Fill to the top, walking every flag boundary (R2, R5, R6).
        for (int i = 0; i < 64; i++) cyc(1'b1, 1'b0, W'(i * 37 + 5));
        // R2: store while full is ignored; later draining would expose it.
        cyc(1'b1, 1'b0, 9'h1AA);
        cyc(1'b1, 1'b0, 9'h155);
        // R8: both strobes while full -> only the removal.
        cyc(1'b1, 1'b1, 9'h0F0);
        // R8: both strobes in the middle -> occupancy unchanged.
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, W'(9'h100 + i));
        // R7: output enable low forces zero and does not disturb storage.
        out_en = 1'b0; #0.3;
        chk("R7 data_out gated", 32'(data_out), 32'h0);
        out_en = 1'b1; #0.3;
        chk("R7 head kept", 32'(data_out), 32'(q[0]));
        // Drain everything; the monitor checks order (R4).
        for (int i = 0; i < 64; i++) cyc(1'b0, 1'b1, '0);
        cyc(1'b0, 1'b1, '0);
        // R8: both strobes while empty -> only the store.
        cyc(1'b1, 1'b1, 9'h0A5);
        chk("R4 head shown", 32'(data_out), 32'h0A5);
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, W'(i + 300));
        // R1: reset in mid-run empties the buffer.
        do_reset();

        // R9: depth chain, 70 words in without draining.
        for (int k = 0; k < 70; k++) begin
            c_si = 1'b1; c_din = CW'(k);
            @(posedge clk); #1;
        end
        c_si = 1'b0;
        repeat (80) @(posedge clk);
        #1;
        chk("R9 downstream full", 32'(dn_ir), 32'h0);
        chk("R9 upstream holds rest", 32'(up_or), 32'h1);
        chk("R9 upstream near_edge", 32'(up_ne), 32'h1);
        chk("R9 downstream half_up", 32'(dn_hf), 32'h1);
        c_so = 1'b1;
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            chk("R9 chain ready", 32'(dn_or), 32'h1);
            chk("R9 chain order", 32'(dn_dout), 32'(CW'(k)));
            @(posedge clk);
        end
        #1;
        c_so = 1'b0;
        chk("R9 chain empty", 32'(dn_or), 32'h0);
        chk("R9 upstream empty", 32'(up_or), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule